// File: doc/BRIEF.md
# Software Watchdog Timer

This block is a restartable watchdog timer that running software must keep servicing. Software services it by toggling a strobe line. Every change of that line, rising or falling, restarts the timeout. If the line stays at one level for the whole selected period, the block raises `wdt_expired`. Other logic can use that output to reset the processor or to raise an interrupt.

Two inputs set the period. A two-bit selector chooses one of four base periods. A scale bit multiplies the chosen base period by a large fixed factor. The block has no enable and no disable input. Once reset is released it always counts, and only the system reset stops it.

A configuration parameter sets how a timeout ends. In the default mode, the next strobe transition clears the timeout and starts a new period. In the latched mode, the timeout stays set until the system reset. This block does not stretch the reset pulse; another block does that.

Top module: `soft_watchdog`

## Requirements
- R1: While `rst_n` is low, `wdt_expired` is 0. Counting starts at the first clock edge with reset released. With no strobe activity, `wdt_expired` rises at the (L×TICK_DIV)-th rising edge after release, where L is the active limit in ticks.
- R2: Every change of `wdt_strobe`, rising or falling, restarts the period. The strobe passes through a two-flop synchronizer and an edge detector. The new period starts at the 3rd rising edge after the change. `wdt_expired` then rises at the (L×TICK_DIV+3)-th rising edge after the change.
- R3: `period_sel` values 0, 1, 2 and 3 choose base limits PERIOD0, PERIOD1, PERIOD2 and PERIOD3 ticks. The defaults are 43, 710, 11200 and 179000 ticks of 0.1 ms, which give 4.3 ms, 71 ms, 1.12 s and 17.9 s.
- R4: When `scale_x500` is 1, the active limit is the selected base limit multiplied by SCALE_MULT (default 500). When it is 0, the factor is 1.
- R5: A strobe held at a constant level, high or low, never restarts the period.
- R6: With CLEAR_ON_STROBE=1, `wdt_expired` stays 1 until a strobe transition. That transition clears it at the 3rd rising edge after the change and starts a new full period at the same edge.
- R7: With CLEAR_ON_STROBE=0, once `wdt_expired` is 1 it stays 1 until `rst_n` goes low. Strobe transitions have no effect on it.
- R8: The elapsed count is compared against the live limit with "greater or equal". After a change of `period_sel` or `scale_x500`, a count that already reaches the new limit expires at the next tick. A larger new limit extends the current period.
- R9: No combination of `period_sel` and `scale_x500` stops counting. Even the largest setting ends in a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset; clears and holds the watchdog |
| wdt_strobe | input | 1 | Asynchronous service line; any transition restarts the period |
| period_sel | input | 2 | Base period select (0 shortest .. 3 longest) |
| scale_x500 | input | 1 | 1 multiplies the base period by SCALE_MULT |
| wdt_expired | output | 1 | High while a timeout is flagged |

## Verification
The hardest case to produce from the ports is a change of the period while a count is in progress. To hit a chosen elapsed count, the stimulus must land on an exact clock cycle. The bench counts cycles from the release of reset and changes `period_sel` on the falling edge right after a known tick. It does this once to shorten the period below the count already reached, and once to lengthen it. The latched mode is covered by a second instance that shares every input with the first. This shows at the ports that the same strobe edges clear one instance and leave the other set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned NUM_PERIODS = 4;

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int unsigned scaled_limit(input int unsigned base, input logic scale_on,
                                               input int unsigned mult);
    return scale_on ? base * mult : base;
  endfunction

  function automatic logic limit_reached(input int unsigned next_count, input int unsigned limit);
    return next_count >= limit;
  endfunction

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              delayed;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) delayed <= 1'b0;
    else        delayed <= chain[STAGES-1];
  end

  assign edge_o = chain[STAGES-1] ^ delayed;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_DIV = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick_o
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign tick_o = (div_q == LAST) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      div_q <= '0;
    else if (restart || div_q == LAST) div_q <= '0;
    else                             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_timeout_core.sv
module wdt_timeout_core #(
  parameter int unsigned CNT_W = 27,
  parameter bit CLEAR_ON_STROBE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] elapsed,
  output logic             expired
);
  logic kick_accepted;
  logic reach;

  assign kick_accepted = kick && (!expired || CLEAR_ON_STROBE);
  assign reach = wdt_pkg::limit_reached(32'(elapsed) + 32'd1, 32'(limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      expired <= 1'b0;
    end else if (kick_accepted) begin
      elapsed <= '0;
      expired <= 1'b0;
    end else if (tick && !expired) begin
      if (reach) expired <= 1'b1;
      else       elapsed <= elapsed + 1'b1;
    end
  end
endmodule

// File: rtl/soft_watchdog.sv
module soft_watchdog #(
  parameter int unsigned TICK_DIV        = 5000,
  parameter int unsigned PERIOD0         = 43,
  parameter int unsigned PERIOD1         = 710,
  parameter int unsigned PERIOD2         = 11200,
  parameter int unsigned PERIOD3         = 179000,
  parameter int unsigned SCALE_MULT      = 500,
  parameter int unsigned SYNC_STAGES     = 2,
  parameter bit          CLEAR_ON_STROBE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wdt_strobe,
  input  logic [1:0] period_sel,
  input  logic       scale_x500,
  output logic       wdt_expired
);
  localparam int unsigned MAX_LIMIT =
    wdt_pkg::max_of4(PERIOD0, PERIOD1, PERIOD2, PERIOD3) * SCALE_MULT;
  localparam int unsigned CNT_W = wdt_pkg::bits_for(MAX_LIMIT);
  localparam int unsigned BASE_TABLE [wdt_pkg::NUM_PERIODS] =
    '{PERIOD0, PERIOD1, PERIOD2, PERIOD3};

  logic             kick;
  logic             tick;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] elapsed;
  int unsigned      base_sel;

  always_comb begin
    base_sel = BASE_TABLE[period_sel];
    limit    = CNT_W'(wdt_pkg::scaled_limit(base_sel, scale_x500, SCALE_MULT));
  end

  wdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(wdt_strobe), .edge_o(kick)
  );

  wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk(clk), .rst_n(rst_n), .restart(kick), .tick_o(tick)
  );

  wdt_timeout_core #(.CNT_W(CNT_W), .CLEAR_ON_STROBE(CLEAR_ON_STROBE)) u_core (
    .clk(clk), .rst_n(rst_n), .kick(kick), .tick(tick), .limit(limit),
    .elapsed(elapsed), .expired(wdt_expired)
  );
endmodule

// File: rtl/soft_watchdog_checker.sv
module soft_watchdog_checker #(
  parameter int unsigned CNT_W = 27,
  parameter bit CLEAR_ON_STROBE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kick,
  input logic             tick,
  input logic             expired,
  input logic [CNT_W-1:0] elapsed,
  input logic [CNT_W-1:0] limit
);
  // R2, R6: an accepted kick restarts the count and clears the flag
  a_r2_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    kick && (!expired || CLEAR_ON_STROBE) |=> (elapsed == '0) && !expired);

  // R1: a timeout only starts on a prescaler tick
  a_r1_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(tick));

  // R8: reaching the live limit on a tick raises the flag
  a_r8_limit_expires: assert property (@(posedge clk) disable iff (!rst_n)
    !expired && !kick && tick && (32'(elapsed) + 32'd1 >= 32'(limit)) |=> expired);

  // R6: without a kick the flag holds and the count freezes
  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    expired && !kick |=> expired && $stable(elapsed));

  // R7: latched mode keeps the flag until reset
  a_r7_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (!CLEAR_ON_STROBE && expired) |=> expired);
endmodule

bind soft_watchdog soft_watchdog_checker #(.CNT_W(CNT_W), .CLEAR_ON_STROBE(CLEAR_ON_STROBE)) u_chk (
  .clk(clk), .rst_n(rst_n), .kick(kick), .tick(tick), .expired(wdt_expired),
  .elapsed(elapsed), .limit(limit)
);

// File: tb/soft_watchdog_test.sv
`timescale 1ns/1ps
module soft_watchdog_test;
  localparam int D  = 2;
  localparam int P0 = 5, P1 = 9, P2 = 14, P3 = 20, MULT = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [1:0] sel = 2'd0;
  logic scale = 1'b0;
  logic exp_u, exp_s;
  int cyc = 0;
  int checks = 0;
  int fails = 0;

  typedef struct {
    int    at;
    bit    val;
    bit    dut;
    string req;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  soft_watchdog #(.TICK_DIV(D), .PERIOD0(P0), .PERIOD1(P1), .PERIOD2(P2), .PERIOD3(P3),
    .SCALE_MULT(MULT), .CLEAR_ON_STROBE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wdt_strobe(strobe), .period_sel(sel),
    .scale_x500(scale), .wdt_expired(exp_u));

  soft_watchdog #(.TICK_DIV(D), .PERIOD0(P0), .PERIOD1(P1), .PERIOD2(P2), .PERIOD3(P3),
    .SCALE_MULT(MULT), .CLEAR_ON_STROBE(1'b0)) uut_latched (
    .clk(clk), .rst_n(rst_n), .wdt_strobe(strobe), .period_sel(sel),
    .scale_x500(scale), .wdt_expired(exp_s));

  function automatic int limit_of(input int s, input bit sc);
    int b;
    case (s)
      0: b = P0;
      1: b = P1;
      2: b = P2;
      default: b = P3;
    endcase
    return sc ? b * MULT : b;
  endfunction

  task automatic push(input int at, input bit val, input bit dut, input string req);
    item_t it;
    it.at = at; it.val = val; it.dut = dut; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: compare scoreboard items in the cycle they are due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      item_t it;
      logic act;
      it = sb.pop_front();
      act = it.dut ? exp_s : exp_u;
      checks++;
      if (it.at != cyc || act !== it.val) begin
        fails++;
        $display("FAIL %s dut=%0d cycle=%0d: actual=%b expected=%b (due cycle %0d)",
                 it.req, it.dut, cyc, act, it.val, it.at);
      end
    end
  end

  // hold reset, apply config, release; returns release cycle
  task automatic do_reset(input logic [1:0] s, input bit sc, output int c0);
    @(negedge clk);
    rst_n = 1'b0;
    strobe = 1'b0;
    sel = s;
    scale = sc;
    repeat (3) @(negedge clk);
    checks++;
    if (exp_u !== 1'b0 || exp_s !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset state: actual=%b/%b expected=0/0", exp_u, exp_s);
    end
    rst_n = 1'b1;
    c0 = cyc;
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    int c0;
    int c;
    int lim;
    // R1: reset state and first period after release
    do_reset(2'd0, 1'b0, c0);
    push(c0 + 2*P0 - 1, 1'b0, 1'b0, "R1");
    push(c0 + 2*P0 - 1, 1'b0, 1'b1, "R1");
    push(c0 + 2*P0, 1'b1, 1'b0, "R1");
    push(c0 + 2*P0, 1'b1, 1'b1, "R1");
    wait_to(c0 + 2*P0 + 2);
    drain();

    // R6 clear on strobe, R7 latched ignores strobe, R2 rising edge restart
    c = cyc;
    push(c + 2, 1'b1, 1'b0, "R6");
    push(c + 3, 1'b0, 1'b0, "R6");
    push(c + 3, 1'b1, 1'b1, "R7");
    push(c + 3 + 2*P0 - 1, 1'b0, 1'b0, "R2");
    push(c + 3 + 2*P0, 1'b1, 1'b0, "R2");
    push(c + 3 + 2*P0, 1'b1, 1'b1, "R7");
    push(c + 18, 1'b0, 1'b0, "R6");
    push(c + 20, 1'b1, 1'b1, "R7");
    strobe = 1'b1;
    wait_to(c + 15);
    strobe = 1'b0;
    drain();

    // R2: repeated restarts on alternating edges keep the timeout away
    do_reset(2'd0, 1'b0, c0);
    push(c0 + 4, 1'b0, 1'b0, "R2");
    for (int k = 1; k <= 4; k++) push(c0 + 4 + 6*k, 1'b0, 1'b0, "R2");
    push(c0 + 28 + 2*P0 + 2, 1'b0, 1'b0, "R2");
    push(c0 + 28 + 2*P0 + 3, 1'b1, 1'b0, "R2");
    for (int k = 0; k <= 4; k++) begin
      wait_to(c0 + 4 + 6*k);
      strobe = ~strobe;
    end
    drain();

    // R5: level held high never restarts
    do_reset(2'd0, 1'b0, c0);
    wait_to(c0 + 2);
    c = cyc;
    push(c + 3 + 2*P0, 1'b1, 1'b0, "R5");
    push(c + 40, 1'b1, 1'b0, "R5");
    strobe = 1'b1;
    drain();

    // R3: each period select
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s), 1'b0, c0);
      lim = limit_of(s, 1'b0);
      push(c0 + D*lim - 1, 1'b0, 1'b0, "R3");
      push(c0 + D*lim, 1'b1, 1'b0, "R3");
      drain();
    end

    // R4: scale multiplier
    for (int s = 0; s < 2; s++) begin
      do_reset(2'(s), 1'b1, c0);
      lim = limit_of(s, 1'b1);
      push(c0 + D*limit_of(s, 1'b0), 1'b0, 1'b0, "R4");
      push(c0 + D*lim - 1, 1'b0, 1'b0, "R4");
      push(c0 + D*lim, 1'b1, 1'b0, "R4");
      drain();
    end

    // R8: shorten below the count already reached
    do_reset(2'd3, 1'b0, c0);
    push(c0 + 25, 1'b0, 1'b0, "R8");
    push(c0 + 26, 1'b1, 1'b0, "R8");
    wait_to(c0 + 24);
    sel = 2'd0;
    drain();

    // R8: lengthen mid-period
    do_reset(2'd0, 1'b0, c0);
    push(c0 + 2*P0, 1'b0, 1'b0, "R8");
    push(c0 + 2*P3 - 1, 1'b0, 1'b0, "R8");
    push(c0 + 2*P3, 1'b1, 1'b0, "R8");
    wait_to(c0 + 4);
    sel = 2'd3;
    drain();

    // R9: largest setting still times out
    do_reset(2'd3, 1'b1, c0);
    lim = limit_of(3, 1'b1);
    push(c0 + D*lim - 1, 1'b0, 1'b0, "R9");
    push(c0 + D*lim, 1'b1, 1'b0, "R9");
    push(c0 + D*lim, 1'b1, 1'b1, "R9");
    drain();

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc == 190000);
    fails++;
    $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule